// File: doc/BRIEF.md
# Banked Memory Window Address Translator

This block sits between an 8-bit processor with a 16-bit address bus and a 128 KiB static RAM. On every bus cycle it derives the three upper RAM address lines from the processor address and a 3-bit bank value. The 16 KiB window at $8000..$BFFF is steered onto one of five physical 16 KiB blocks. Every other address maps straight through into the low 64 KiB. The translation is purely combinational from the current address and the registered bank value, so it follows the processor cycle by cycle.

The bank value sits in a small register. The processor loads it by writing to one decoded address. The same address path also feeds a page decoder. That decoder drives five active-low select lines with a resolution of one 256-byte page: one for the RAM and four for other devices.

Top module: `bankwin_xlate`

## Requirements
- R1: When cpu_addr[15:14] is 2'b10, sram_hi is 3'b010 for bank 0, 3'b100 for bank 1, 3'b101 for bank 2, 3'b110 for bank 3 and 3'b111 for bank 4.
- R2: Bank values 5, 6 and 7 act like bank 0 and give sram_hi = 3'b010 inside the window.
- R3: When cpu_addr[15:14] is not 2'b10, sram_hi is {1'b0, cpu_addr[15:14]}, whatever the bank value.
- R4: On a rising clk edge where bank_we is 1 and cpu_addr equals $C000, the bank register takes bank_wdata. The new value governs sram_hi from the following cycle onwards.
- R5: In any other cycle the bank register keeps its value. This includes a write strobe to any address other than $C000, and bank_wdata changing while bank_we is 0.
- R6: An active-low rst_n clears the bank register to 0, so the window then shows physical $08000..$0BFFF (sram_hi = 3'b010).
- R7: cs_n[0] (RAM) is low for pages $00..$BF, which includes the whole window.
- R8: cs_n[1] is low for page $C0, cs_n[2] for page $C1, cs_n[3] for pages $C2..$DF, and cs_n[4] for pages $E0..$FF.
- R9: In every cycle exactly one bit of cs_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor address of the current cycle |
| bank_we | input | 1 | Write strobe for the bank register |
| bank_wdata | input | 3 | Bank value written on a strobe to $C000 |
| sram_hi | output | 3 | RAM address lines 16..14 |
| cs_n | output | 5 | Active-low selects: 0 RAM, 1 page $C0, 2 page $C1, 3 pages $C2..$DF, 4 pages $E0..$FF |

## Verification
The bench puts every bank value, including the three reserved ones, against addresses at both edges of the window. A design that treats a reserved value as a physical block would drive 3'b1xx where 3'b010 is expected. A window compare that is off by one would shift $7FFF or $C000 into a bank.

Page boundaries $BF/$C0, $C1/$C2 and $DF/$E0 are probed one at a time. A wrong boundary shows up as two selects low, or none.

Strobes to a neighbouring address, data that moves while the strobe is low, and a reset in the middle of a run all target the bank register. A loose address match or a missing reset would leave the window on the wrong block.

// File: rtl/bankwin_pkg.sv
package bankwin_pkg;
    localparam int BANK_W   = 3;
    localparam int HI_W     = 3;
    localparam int NUM_CS   = 5;
    localparam int CS_IDX_W = $clog2(NUM_CS);

    typedef logic [BANK_W-1:0] bank_t;

    typedef struct packed {
        bank_t bank;
    } bank_state_t;

    // index of the select line that a page drives low
    localparam logic [CS_IDX_W-1:0] SEL_RAM = CS_IDX_W'(0);
    localparam logic [CS_IDX_W-1:0] SEL_IO0 = CS_IDX_W'(1);
    localparam logic [CS_IDX_W-1:0] SEL_IO1 = CS_IDX_W'(2);
    localparam logic [CS_IDX_W-1:0] SEL_EXP = CS_IDX_W'(3);
    localparam logic [CS_IDX_W-1:0] SEL_ROM = CS_IDX_W'(4);
endpackage

// File: rtl/bankwin_bank_reg.sv
module bankwin_bank_reg
    import bankwin_pkg::*;
#(
    parameter int           ADDR_W   = 16,
    parameter logic [15:0]  REG_ADDR = 16'hC000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  bank_t             wdata,
    output bank_t             bank
);
    bank_state_t state_d, state_q;
    logic        hit;

    always_comb begin
        hit     = wr_en && (addr == ADDR_W'(REG_ADDR));
        state_d = state_q;
        if (hit) begin
            state_d.bank = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign bank = state_q.bank;

    // R4
    bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(REG_ADDR)) |=> (bank == $past(wdata)));

    // R5
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == ADDR_W'(REG_ADDR)) |=> $stable(bank));

    // R6
    bank_reset_chk: assert property (@(posedge clk)
        !rst_n |-> (bank == '0));
endmodule

// File: rtl/bankwin_hi_map.sv
module bankwin_hi_map
    import bankwin_pkg::*;
#(
    parameter int NUM_BANKS = 5
) (
    input  logic [1:0]      a_top,
    input  bank_t           bank,
    output logic [HI_W-1:0] hi
);
    localparam logic [1:0]      WIN_CODE = 2'b10;
    localparam logic [HI_W-1:0] HOME_HI  = {1'b0, WIN_CODE};

    logic  in_win;
    logic  valid_alt;
    bank_t alt_idx;

    always_comb begin
        in_win    = (a_top == WIN_CODE);
        valid_alt = (bank != '0) && (int'(bank) < NUM_BANKS);
        alt_idx   = bank - bank_t'(1);
        if (!in_win) begin
            hi = {1'b0, a_top};
        end else if (valid_alt) begin
            hi = {1'b1, alt_idx[1:0]};
        end else begin
            hi = HOME_HI;
        end
    end
endmodule

// File: rtl/bankwin_page_dec.sv
module bankwin_page_dec
    import bankwin_pkg::*;
#(
    parameter logic [7:0] RAM_LAST_PG  = 8'hBF,
    parameter logic [7:0] IO0_PG       = 8'hC0,
    parameter logic [7:0] IO1_PG       = 8'hC1,
    parameter logic [7:0] ROM_FIRST_PG = 8'hE0
) (
    input  logic [7:0]          page,
    output logic [CS_IDX_W-1:0] sel
);
    always_comb begin
        if (page <= RAM_LAST_PG) begin
            sel = SEL_RAM;
        end else if (page == IO0_PG) begin
            sel = SEL_IO0;
        end else if (page == IO1_PG) begin
            sel = SEL_IO1;
        end else if (page >= ROM_FIRST_PG) begin
            sel = SEL_ROM;
        end else begin
            sel = SEL_EXP;
        end
    end
endmodule

// File: rtl/bankwin_xlate.sv
module bankwin_xlate
    import bankwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic              bank_we,
    input  logic [2:0]        bank_wdata,
    output logic [2:0]        sram_hi,
    output logic [4:0]        cs_n
);
    bank_t                bank_q;
    logic [CS_IDX_W-1:0]  sel;

    bankwin_bank_reg #(.ADDR_W(16), .REG_ADDR(16'hC000)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (cpu_addr),
        .wr_en (bank_we),
        .wdata (bank_wdata),
        .bank  (bank_q)
    );

    bankwin_hi_map #(.NUM_BANKS(5)) u_hi (
        .a_top (cpu_addr[15:14]),
        .bank  (bank_q),
        .hi    (sram_hi)
    );

    bankwin_page_dec u_pg (
        .page (cpu_addr[15:8]),
        .sel  (sel)
    );

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign cs_n[i] = (sel != CS_IDX_W'(i));
    end

    // R1
    window_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'b10 && bank_q != 3'd0 && bank_q < 3'd5)
        |-> (sram_hi[2] && sram_hi[1:0] == 2'(bank_q - 3'd1)));

    // R2
    reserved_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'b10 && (bank_q == 3'd0 || bank_q >= 3'd5))
        |-> (sram_hi == 3'b010));

    // R3
    outside_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] != 2'b10) |-> (!sram_hi[2] && sram_hi[1:0] == cpu_addr[15:14]));

    // R7
    ram_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:8] <= 8'hBF) |-> !cs_n[0]);

    // R9
    one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) == 1);
endmodule

// File: tb/bankwin_xlate_tb_top.sv
module bankwin_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic        bank_we = 1'b0;
    logic [2:0]  bank_wdata = 3'd0;
    logic [2:0]  sram_hi;
    logic [4:0]  cs_n;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    bankwin_xlate dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_addr   (cpu_addr),
        .bank_we    (bank_we),
        .bank_wdata (bank_wdata),
        .sram_hi    (sram_hi),
        .cs_n       (cs_n)
    );

    // {bank[2:0], addr[15:0], exp_hi[2:0], exp_cs_n[4:0]}
    localparam int NV = 17;
    localparam logic [26:0] VEC [NV] = '{
        {3'd0, 16'h8000, 3'b010, 5'b11110},  // R1
        {3'd1, 16'h8000, 3'b100, 5'b11110},  // R1
        {3'd2, 16'h9234, 3'b101, 5'b11110},  // R1
        {3'd3, 16'hA000, 3'b110, 5'b11110},  // R1
        {3'd4, 16'hBFFF, 3'b111, 5'b11110},  // R1 R7
        {3'd5, 16'h8123, 3'b010, 5'b11110},  // R2
        {3'd6, 16'hB000, 3'b010, 5'b11110},  // R2
        {3'd7, 16'h8800, 3'b010, 5'b11110},  // R2
        {3'd4, 16'h7FFF, 3'b001, 5'b11110},  // R3
        {3'd4, 16'hC0FF, 3'b011, 5'b11101},  // R3 R8
        {3'd3, 16'hC1FF, 3'b011, 5'b11011},  // R8
        {3'd2, 16'hC200, 3'b011, 5'b10111},  // R8
        {3'd1, 16'hDFFF, 3'b011, 5'b10111},  // R8
        {3'd1, 16'hE000, 3'b011, 5'b01111},  // R8
        {3'd2, 16'hFFFF, 3'b011, 5'b01111},  // R8
        {3'd3, 16'h0000, 3'b000, 5'b11110},  // R3 R7
        {3'd4, 16'h4000, 3'b001, 5'b11110}   // R3
    };

    task automatic write_bank(input logic [2:0] b, input logic [15:0] a);
        @(negedge clk);
        cpu_addr   = a;
        bank_wdata = b;
        bank_we    = 1'b1;
        @(negedge clk);
        bank_we    = 1'b0;
    endtask

    task automatic probe(input logic [15:0] a, input logic [2:0] exp_hi,
                         input logic [4:0] exp_cs, input string tag);
        cpu_addr = a;
        #1;
        n_tests++;
        if (sram_hi !== exp_hi || cs_n !== exp_cs) begin
            n_fail++;
            $display("FAIL %s addr=%h hi=%b cs_n=%b expected hi=%b cs_n=%b",
                     tag, a, sram_hi, cs_n, exp_hi, exp_cs);
        end
        // R9 exactly one select low
        n_tests++;
        if ($countones(~cs_n) != 1) begin
            n_fail++;
            $display("FAIL R9 addr=%h cs_n=%b expected one low bit", a, cs_n);
        end
    endtask

    initial begin : watchdog
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog expired, actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R6 reset state: window shows home block
        probe(16'h8000, 3'b010, 5'b11110, "R6 reset");
        rst_n = 1'b1;
        @(negedge clk);
        probe(16'h9FFF, 3'b010, 5'b11110, "R6 after release");

        for (int i = 0; i < NV; i++) begin
            write_bank(VEC[i][26:24], 16'hC000);
            probe(VEC[i][23:8], VEC[i][7:5], VEC[i][4:0], "R1/R2/R3/R7/R8 vector");
        end

        // R4 new value governs the very next cycle
        write_bank(3'd3, 16'hC000);
        probe(16'hA5A5, 3'b110, 5'b11110, "R4 load");

        // R5 strobe to neighbour addresses ignored
        write_bank(3'd1, 16'hC001);
        probe(16'h8000, 3'b110, 5'b11110, "R5 wrong addr C001");
        write_bank(3'd2, 16'h4000);
        probe(16'h8000, 3'b110, 5'b11110, "R5 wrong addr 4000");

        // R5 data moves without strobe
        @(negedge clk);
        cpu_addr   = 16'hC000;
        bank_wdata = 3'd4;
        @(negedge clk);
        probe(16'hBFFF, 3'b110, 5'b11110, "R5 no strobe");

        // R6 reset mid-run
        write_bank(3'd4, 16'hC000);
        probe(16'h8000, 3'b111, 5'b11110, "R4 load bank4");
        rst_n = 1'b0;
        #1;
        probe(16'h8000, 3'b010, 5'b11110, "R6 mid-run reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        probe(16'hB000, 3'b010, 5'b11110, "R6 after second release");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule